// File: doc/BRIEF.md
# Bit-Serial Global Reduction Unit

This unit sits on the control side of a linear SIMD array. Each processing element (PE) presents one signed operand, and the unit folds all of them into a single scalar. The folding is done one bit slice per clock across every PE at once, so no parallel adder or comparator tree is needed. The supported reductions are signed sum, signed minimum, signed maximum, and bitwise AND, OR and XOR. A per-PE mask leaves PEs out of a reduction.

Software pulses `start` with an opcode, a mask and the operand vector. The unit captures all three and works through the slices, then publishes the result with a one-cycle `done` pulse. When the accumulate flag is set on a sum, the reduced value is also added into a running 64-bit control-unit total. This total wraps modulo 2^64.

Top module: `serial_reduce_net`

## Requirements
- R1: After reset, `result` and `acc_total` are zero and `done` and `busy` are low.
- R2: A `start` seen while idle captures `op`, `mask`, `accum` and `operands`, and raises `busy` at that edge. `done` is high for exactly one cycle, OPW+1 clock edges after the capturing edge, and `busy` drops at that same edge.
- R3: A `start` seen while `busy` is high has no effect. The running reduction finishes with the values captured at its own start.
- R4: Opcode 0 (sum) produces the two's-complement sum of the masked operands, sign-extended to ACCW bits. A masked-off PE contributes 0, and an empty mask yields 0.
- R5: Opcode 1 (min) produces the smallest masked operand as a signed value, sign-extended to ACCW bits. An empty mask yields 2^(OPW-1)-1.
- R6: Opcode 2 (max) produces the largest masked operand as a signed value, sign-extended to ACCW bits. An empty mask yields -2^(OPW-1).
- R7: Opcodes 3, 4 and 5 (AND, OR, XOR) produce the bitwise reduction of the masked operands, zero-extended to ACCW bits. A masked-off PE counts as all ones for AND and as zero for OR and XOR.
- R8: On the `done` edge of a sum started with `accum`=1, `acc_total` becomes its old value plus `result`, modulo 2^ACCW. For any other reduction, `acc_total` is unchanged.
- R9: `result` changes only at the edge that raises `done`, and it holds between reductions.
- R10: Opcodes 6 and 7 are reserved. Each produces a result of 0 with the normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction when idle |
| op | input | 3 | Reduction opcode (0 sum, 1 min, 2 max, 3 and, 4 or, 5 xor) |
| accum | input | 1 | Add a sum result into the running total |
| mask | input | NUM_PE | Per-PE participation, 1 = included |
| operands | input | NUM_PE*OPW | PE operands, PE i at bits [i*OPW +: OPW] |
| result | output | ACCW | Latest reduction result |
| acc_total | output | ACCW | Running control-unit sum |
| done | output | 1 | One-cycle pulse when result is updated |
| busy | output | 1 | Reduction in progress |

## Verification
A reduction captured at clock edge N raises `busy` at N. It delivers `result`, `done` and any accumulated total at edge N+OPW+1, which is N+25 with the default parameters. The bench model applies the same edge counts to its own queue of pending work. It compares every output on each falling edge, so a result that arrives one cycle early or late is caught as well as a wrong value. A start issued mid-reduction is checked by comparing the final result against the value computed from the first capture.

// File: rtl/serial_reduce_pkg.sv
package serial_reduce_pkg;
  typedef enum logic [2:0] {
    RD_SUM  = 3'd0,
    RD_MIN  = 3'd1,
    RD_MAX  = 3'd2,
    RD_AND  = 3'd3,
    RD_OR   = 3'd4,
    RD_XOR  = 3'd5,
    RD_RSV6 = 3'd6,
    RD_RSV7 = 3'd7
  } rd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/rd_ctrl.sv
module rd_ctrl
  import serial_reduce_pkg::*;
#(
  parameter int OPW  = 24,
  parameter int IDXW = $clog2(OPW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            accept,
  output logic            run,
  output logic            fin,
  output logic            busy,
  output logic [IDXW-1:0] cnt,
  output logic            first,
  output logic            last
);
  localparam logic [IDXW-1:0] LastIdx = IDXW'(OPW - 1);

  rd_state_e       state_q, state_n;
  logic [IDXW-1:0] cnt_q, cnt_n;

  assign accept = (state_q == ST_IDLE) && start;
  assign run    = (state_q == ST_RUN);
  assign fin    = (state_q == ST_FIN);
  assign busy   = (state_q != ST_IDLE);
  assign cnt    = cnt_q;
  assign first  = (cnt_q == '0);
  assign last   = (cnt_q == LastIdx);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_RUN;
        cnt_n   = '0;
      end
      ST_RUN: begin
        if (last) state_n = ST_FIN;
        else      cnt_n   = cnt_q + 1'b1;
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> ($past(cnt_q) == LastIdx));

  assert_fin_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/rd_slice_pick.sv
module rd_slice_pick #(
  parameter int NUM_PE = 64,
  parameter int OPW    = 24,
  parameter int IDXW   = $clog2(OPW)
) (
  input  logic [NUM_PE*OPW-1:0] opnd,
  input  logic [IDXW-1:0]       idx,
  input  logic                  invert,
  output logic [NUM_PE-1:0]     slice
);
  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic [OPW-1:0] word;
    assign word     = opnd[g*OPW +: OPW];
    assign slice[g] = word[idx] ^ invert;
  end
endmodule

// File: rtl/rd_slice_reduce.sv
module rd_slice_reduce #(
  parameter int NUM_PE = 64,
  parameter int PCW    = $clog2(NUM_PE + 1)
) (
  input  logic [NUM_PE-1:0] slice,
  input  logic [NUM_PE-1:0] mask,
  input  logic [NUM_PE-1:0] cand,
  output logic [PCW-1:0]    pop,
  output logic              any_c1,
  output logic              any_c0,
  output logic              and_b,
  output logic              or_b,
  output logic              xor_b
);
  logic [NUM_PE-1:0] live;

  assign live   = slice & mask;
  assign any_c1 = |(cand & slice);
  assign any_c0 = |(cand & ~slice);
  assign and_b  = &(slice | ~mask);
  assign or_b   = |live;
  assign xor_b  = ^live;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_PE; i++) pop = pop + PCW'(live[i]);
  end
endmodule

// File: rtl/serial_reduce_net.sv
module serial_reduce_net
  import serial_reduce_pkg::*;
#(
  parameter int NUM_PE = 64,
  parameter int OPW    = 24,
  parameter int ACCW   = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            op,
  input  logic                  accum,
  input  logic [NUM_PE-1:0]     mask,
  input  logic [NUM_PE*OPW-1:0] operands,
  output logic [ACCW-1:0]       result,
  output logic [ACCW-1:0]       acc_total,
  output logic                  done,
  output logic                  busy
);
  localparam int IDXW = $clog2(OPW);
  localparam int PCW  = $clog2(NUM_PE + 1);
  localparam int CW   = PCW + 1;
  localparam logic [IDXW-1:0] TopIdx = IDXW'(OPW - 1);

  // control
  logic            accept, run, fin, first, last;
  logic [IDXW-1:0] cnt;

  rd_ctrl #(.OPW(OPW), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .run(run),
    .fin(fin), .busy(busy), .cnt(cnt), .first(first), .last(last)
  );

  // captured state
  rd_op_e                op_q;
  logic                  accum_q;
  logic [NUM_PE-1:0]     mask_q, cand_q, cand_n;
  logic [NUM_PE*OPW-1:0] opnd_q;
  logic [CW-1:0]         carry_q, carry_n;
  logic [OPW-1:0]        bits_q, bits_n;
  logic [ACCW-1:0]       result_q, acc_q, fin_val;
  logic                  done_q;

  logic is_mm;
  assign is_mm = (op_q == RD_MIN) || (op_q == RD_MAX);

  // slice selection: min/max walk from the top bit, others from bit 0
  logic [IDXW-1:0]   idx;
  logic              invert;
  logic [NUM_PE-1:0] slice;

  assign idx    = is_mm ? (TopIdx - cnt) : cnt;
  assign invert = is_mm && first;

  rd_slice_pick #(.NUM_PE(NUM_PE), .OPW(OPW), .IDXW(IDXW)) u_pick (
    .opnd(opnd_q), .idx(idx), .invert(invert), .slice(slice)
  );

  logic [PCW-1:0] pop;
  logic           any_c1, any_c0, and_b, or_b, xor_b;

  rd_slice_reduce #(.NUM_PE(NUM_PE), .PCW(PCW)) u_red (
    .slice(slice), .mask(mask_q), .cand(cand_q), .pop(pop), .any_c1(any_c1),
    .any_c0(any_c0), .and_b(and_b), .or_b(or_b), .xor_b(xor_b)
  );

  // per-slice next state
  logic [CW-1:0] pop_ext, tsum;
  logic          bit_t, bit_store;

  always_comb begin
    pop_ext = CW'(pop);
    tsum    = last ? (carry_q - pop_ext) : (carry_q + pop_ext);
    cand_n  = cand_q;
    carry_n = carry_q;
    bit_t   = 1'b0;
    case (op_q)
      RD_SUM: begin
        bit_t   = tsum[0];
        carry_n = last ? tsum : {1'b0, tsum[CW-1:1]};
      end
      RD_MAX: begin
        bit_t = any_c1;
        if (any_c1) cand_n = cand_q & slice;
      end
      RD_MIN: begin
        bit_t = ~any_c0;
        if (any_c0) cand_n = cand_q & ~slice;
      end
      RD_AND:  bit_t = and_b;
      RD_OR:   bit_t = or_b;
      RD_XOR:  bit_t = xor_b;
      default: bit_t = 1'b0;
    endcase
    bit_store = bit_t ^ invert;
    bits_n    = is_mm ? {bits_q[OPW-2:0], bit_store} : {bit_store, bits_q[OPW-1:1]};
  end

  // final value assembly
  logic [ACCW-1:0] sum_hi;
  always_comb begin
    sum_hi = {{(ACCW-CW){carry_q[CW-1]}}, carry_q};
    case (op_q)
      RD_SUM:  fin_val = (sum_hi << (OPW-1)) | {{(ACCW-OPW+1){1'b0}}, bits_q[OPW-2:0]};
      RD_MIN,
      RD_MAX:  fin_val = {{(ACCW-OPW){bits_q[OPW-1]}}, bits_q};
      RD_AND,
      RD_OR,
      RD_XOR:  fin_val = {{(ACCW-OPW){1'b0}}, bits_q};
      default: fin_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= RD_SUM;
      accum_q <= 1'b0;
      mask_q  <= '0;
      opnd_q  <= '0;
    end else if (accept) begin
      op_q    <= rd_op_e'(op);
      accum_q <= accum;
      mask_q  <= mask;
      opnd_q  <= operands;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= '0;
      carry_q <= '0;
      bits_q  <= '0;
    end else if (accept) begin
      cand_q  <= mask;
      carry_q <= '0;
      bits_q  <= '0;
    end else if (run) begin
      cand_q  <= cand_n;
      carry_q <= carry_n;
      bits_q  <= bits_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) result_q <= fin_val;
      if (fin && accum_q && (op_q == RD_SUM)) acc_q <= acc_q + fin_val;
    end
  end

  assign result    = result_q;
  assign acc_total = acc_q;
  assign done      = done_q;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mask_q) && $stable(op_q) && $stable(opnd_q)));

  assert_cand_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run) |-> ((cand_q & ~$past(cand_q)) == '0));

  assert_cand_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_mm && (|mask_q)) |-> (|cand_q));

  assert_acc_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(accum_q && (op_q == RD_SUM))) |-> (acc_q == $past(acc_q)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q));
endmodule

// File: tb/serial_reduce_net_tb.sv
module serial_reduce_net_tb;
  localparam int NUM_PE = 64;
  localparam int OPW    = 24;
  localparam int ACCW   = 64;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  start;
  logic [2:0]            op;
  logic                  accum;
  logic [NUM_PE-1:0]     mask;
  logic [NUM_PE*OPW-1:0] operands;
  logic [ACCW-1:0]       result, acc_total;
  logic                  done, busy;
  logic [OPW-1:0]        opv [NUM_PE];

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit compare_on = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_PE; i++) operands[i*OPW +: OPW] = opv[i];
  end

  serial_reduce_net #(.NUM_PE(NUM_PE), .OPW(OPW), .ACCW(ACCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .accum(accum), .mask(mask),
    .operands(operands), .result(result), .acc_total(acc_total), .done(done), .busy(busy)
  );

  function automatic string tag_of(int code);
    case (code)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4, 5: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [ACCW-1:0] expect_val(int code);
    longint s = 0;
    int mn = (1 << (OPW-1)) - 1;
    int mx = -(1 << (OPW-1));
    logic [OPW-1:0] a = '1, o = '0, x = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (mask[i]) begin
        int v = int'($signed(opv[i]));
        s += longint'(v);
        if (v < mn) mn = v;
        if (v > mx) mx = v;
        a &= opv[i];
        o |= opv[i];
        x ^= opv[i];
      end
    end
    case (code)
      0: return ACCW'(s);
      1: return ACCW'(longint'(mn));
      2: return ACCW'(longint'(mx));
      3: return ACCW'(a);
      4: return ACCW'(o);
      5: return ACCW'(x);
      default: return '0;
    endcase
  endfunction

  // reference model: queue of pending work, timing counted in edges
  logic [ACCW-1:0] m_result, m_acc, m_pend;
  logic            m_done, m_busy, m_accum_pend;
  int              m_cnt, m_op;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_result = '0; m_acc = '0; m_done = 0; m_busy = 0; m_cnt = 0; m_op = 0;
      m_pend = '0; m_accum_pend = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == OPW) begin
          m_busy = 0;
          m_done = 1;
          m_result = m_pend;
          if (m_accum_pend && m_op == 0) m_acc = m_acc + m_pend;
        end else m_cnt++;
      end else if (start) begin
        m_busy = 1;
        m_cnt = 0;
        m_op = int'(op);
        m_pend = expect_val(int'(op));
        m_accum_pend = accum;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && compare_on && !finished) begin
      checks += 4;
      if (done !== m_done) begin
        errors++; $display("FAIL R2 done actual %0b expected %0b", done, m_done);
      end
      if (busy !== m_busy) begin
        errors++; $display("FAIL R2 busy actual %0b expected %0b", busy, m_busy);
      end
      if (result !== m_result) begin
        errors++; $display("FAIL %s result actual %h expected %h", tag_of(m_op), result, m_result);
      end
      if (acc_total !== m_acc) begin
        errors++; $display("FAIL R8 acc_total actual %h expected %h", acc_total, m_acc);
      end
    end
  end

  task automatic fill_rand();
    for (int i = 0; i < NUM_PE; i++) opv[i] = OPW'($urandom);
  endtask

  task automatic fill_const(logic [OPW-1:0] v);
    for (int i = 0; i < NUM_PE; i++) opv[i] = v;
  endtask

  task automatic launch(int code, logic [NUM_PE-1:0] m, logic acc);
    @(negedge clk);
    op = 3'(code); mask = m; accum = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fill_rand();          // captured values must be used, not live ones
    mask = ~m;
    repeat (OPW + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [ACCW-1:0] exp_r3;
    rst_n = 1'b0; start = 1'b0; op = '0; accum = 1'b0; mask = '0;
    fill_const('0);
    repeat (3) @(negedge clk);
    checks++;
    if (result !== '0 || acc_total !== '0 || done !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %h %h %b %b expected 0 0 0 0", result, acc_total, done, busy);
    end
    rst_n = 1'b1;
    compare_on = 1;

    // R4 sum: random, accumulate, extremes, empty mask
    fill_rand(); launch(0, '1, 1'b1);
    fill_rand(); launch(0, 64'h0F0F_00FF_1234_8001, 1'b1);
    fill_const(24'h7FFFFF); launch(0, '1, 1'b1);
    fill_const(24'h800000); launch(0, '1, 1'b1);
    fill_rand(); launch(0, '0, 1'b1);
    // R8: sum without accumulate leaves total
    fill_rand(); launch(0, '1, 1'b0);

    // R5 / R6 min and max
    for (int k = 0; k < 4; k++) begin
      fill_rand(); launch(1, 64'(k == 0 ? '1 : {$urandom, $urandom}), 1'b1);
      fill_rand(); launch(2, 64'(k == 0 ? '1 : {$urandom, $urandom}), 1'b1);
    end
    fill_const(24'h000005); opv[17] = 24'h800000; opv[40] = 24'h7FFFFF;
    launch(1, '1, 1'b0);
    fill_const(24'h000005); opv[17] = 24'h800000; opv[40] = 24'h7FFFFF;
    launch(2, '1, 1'b0);
    fill_const(24'hFFFFFF); launch(2, 64'h1, 1'b0);   // single PE, value -1
    fill_rand(); launch(1, '0, 1'b0);                 // empty -> max positive
    fill_rand(); launch(2, '0, 1'b0);                 // empty -> most negative

    // R7 logic reductions
    for (int c = 3; c <= 5; c++) begin
      fill_rand(); launch(c, '1, 1'b1);
      fill_rand(); launch(c, 64'hAAAA_5555_F0F0_0001, 1'b0);
      fill_rand(); launch(c, '0, 1'b0);
    end

    // R10 reserved opcodes
    fill_rand(); launch(6, '1, 1'b1);
    fill_rand(); launch(7, '1, 1'b0);

    // R3: start pulses while busy are ignored
    fill_rand();
    @(negedge clk);
    op = 3'd0; mask = '1; accum = 1'b1; start = 1'b1;
    exp_r3 = expect_val(0);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    fill_rand(); op = 3'd2; mask = 64'h3; accum = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (OPW + 2) @(negedge clk);
    checks++;
    if (result !== exp_r3) begin
      errors++;
      $display("FAIL R3 result after ignored start actual %h expected %h", result, exp_r3);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule